// File: doc/BRIEF.md
# Noise and Triangle Wave Generator for a 12-bit Converter Datapath

This block sits in front of a 12-bit digital-to-analog converter and forms the code that is sent to it. A 12-bit base value from the holding register is combined with a wave component. A two-bit mode field picks the wave component. It can be nothing, masked pseudo-random noise from a 12-bit LFSR, or a triangle from an up/down counter. A four-bit amplitude field serves both wave types. In noise mode it sets how many low LFSR bits survive the mask. In triangle mode it sets the triangle peak.

When triggering is disabled, the block copies the base value to the output on every clock, and no wave is added. When triggering is enabled, only a trigger pulse produces a new output. The wave generator state advances once per accepted trigger. The output register has a one-cycle valid strobe, so a consumer latches the result one cycle after the trigger.

Top module: `wave_gen`

## Requirements
- R1: While rst_ni is low, data_o is 0 and valid_o is 0.
- R2: With trig_en_i low, every clock loads data_o with the base_i of the previous cycle and raises valid_o. trig_i, mode_i and amp_i have no effect on data_o. Both wave generators hold their state.
- R3: With trig_en_i high, a trigger accepted in one cycle (trig_i high) makes valid_o high in the next cycle only. A cycle with trig_i low gives valid_o low in the next cycle.
- R4: Mode 2'b00 with triggering enabled outputs base_i unchanged.
- R5: Mode 2'b01 outputs base_i plus (lfsr & mask). The 12-bit LFSR starts at 12'hACE after reset. It shifts left on each trigger accepted in mode 2'b01, and the new bit 0 is lfsr[11]^lfsr[5]^lfsr[3]^lfsr[0]. The value used is the one held before the shift.
- R6: Amplitude code n, for n from 0 to 4, makes the noise mask keep LFSR bits [n:0]. Every code from 5 to 15 keeps bits [5:0].
- R7: Modes 2'b10 and 2'b11 output base_i plus a triangle count. The count starts at 0 and rises by 1 per accepted trigger up to the peak. It then falls by 1 per trigger down to 0, and repeats. The value used is the one held before the step.
- R8: The triangle peak is 2^(n+1)-1 for amplitude code n from 0 to 4. It is 63 for every code of 5 or greater.
- R9: In any cycle where mode_i differs from its value in the previous cycle, the triangle count returns to 0 and its direction to up. A trigger in that same cycle uses count 0. Mode resets to 2'b00 at reset.
- R10: The base-plus-wave sum wraps modulo 4096.
- R11: The LFSR advances only on triggers accepted in noise mode. The triangle count advances only on triggers accepted in triangle mode. Otherwise each holds its state, apart from the R9 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_en_i | input | 1 | Trigger enable; also gates wave generation |
| trig_i | input | 1 | Trigger strobe, one cycle per event |
| mode_i | input | 2 | 00 pass, 01 noise, 1x triangle |
| amp_i | input | 4 | Noise mask width or triangle peak code |
| base_i | input | 12 | Base value from the holding register |
| data_o | output | 12 | Result for the converter |
| valid_o | output | 1 | One-cycle strobe marking a new data_o |

## Verification
The bench targets the turn points of the triangle. A peak off by one would show up in the first turn-around value, and a wrong turn at zero would give a repeated 0 or a negative wrap. It sweeps every amplitude code, including the saturated codes 5 to 15. A design that did not clamp the mask would leak LFSR bits 6 and up into the output. Bases near 4095 expose a sum that saturates instead of wrapping. Mode switches in the middle of a triangle, idle cycles and disabled stretches between triggers catch wave state that advances or fails to clear at the wrong time. Those faults break the LFSR and count sequence that the scoreboard expects.

// File: rtl/wave_gen_pkg.sv
package wave_gen_pkg;
  localparam int unsigned WAVE_W = 6;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_NOISE = 2'b01,
    MODE_TRI_A = 2'b10,
    MODE_TRI_B = 2'b11
  } wave_mode_e;

  // noise mask and triangle peak share one encoding, saturating at code 5
  function automatic logic [WAVE_W-1:0] amp_span(input logic [3:0] code);
    logic [WAVE_W:0] t;
    if (code >= 4'd5) return {WAVE_W{1'b1}};
    t = (7'd2 << code[2:0]) - 7'd1;
    return t[WAVE_W-1:0];
  endfunction
endpackage

// File: rtl/wave_lfsr.sv
module wave_lfsr #(
  parameter int unsigned    W    = 12,
  parameter logic [W-1:0]   SEED = 12'hACE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb = q[11] ^ q[5] ^ q[3] ^ q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (step_i) q <= {q[W-2:0], fb};
  end

  assign state_o = q;
endmodule

// File: rtl/wave_tri.sv
module wave_tri #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic [W-1:0] peak_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_eff, cnt_d;
  logic         down_q, down_eff, down_d;

  assign cnt_eff  = clear_i ? '0 : cnt_q;
  assign down_eff = clear_i ? 1'b0 : down_q;

  always_comb begin
    cnt_d  = cnt_eff;
    down_d = down_eff;
    if (step_i) begin
      if (!down_eff) begin
        if (cnt_eff >= peak_i) begin
          down_d = 1'b1;
          cnt_d  = cnt_eff - 1'b1;
        end else begin
          cnt_d  = cnt_eff + 1'b1;
        end
      end else begin
        if (cnt_eff == '0) begin
          down_d = 1'b0;
          cnt_d  = {{(W-1){1'b0}}, 1'b1};
        end else begin
          cnt_d  = cnt_eff - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o = cnt_eff;
endmodule

// File: rtl/wave_gen.sv
module wave_gen
  import wave_gen_pkg::*;
#(
  parameter int unsigned DW        = 12,
  parameter logic [DW-1:0] LFSR_SEED = 12'hACE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_en_i,
  input  logic          trig_i,
  input  logic [1:0]    mode_i,
  input  logic [3:0]    amp_i,
  input  logic [DW-1:0] base_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  localparam int unsigned PAD = DW - WAVE_W;

  logic [1:0]        mode_q;
  logic              accept, update, mode_chg;
  logic [WAVE_W-1:0] span, tri_cnt, wave;
  logic [DW-1:0]     lfsr;

  assign accept   = trig_en_i & trig_i;
  assign update   = ~trig_en_i | trig_i;
  assign mode_chg = mode_i != mode_q;
  assign span     = amp_span(amp_i);

  wave_lfsr #(.W(DW), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (accept && mode_i == MODE_NOISE),
    .state_o(lfsr)
  );

  wave_tri #(.W(WAVE_W)) u_tri (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(mode_chg),
    .step_i (accept & mode_i[1]),
    .peak_i (span),
    .cnt_o  (tri_cnt)
  );

  always_comb begin
    wave = '0;
    if (trig_en_i) begin
      if (mode_i == MODE_NOISE) wave = lfsr[WAVE_W-1:0] & span;
      else if (mode_i[1])       wave = tri_cnt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_PASS;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      mode_q  <= mode_i;
      valid_o <= update;
      if (update) data_o <= base_i + {{PAD{1'b0}}, wave};
    end
  end
endmodule

// File: rtl/wave_gen_chk.sv
module wave_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        trig_en_i,
  input logic        trig_i,
  input logic [1:0]  mode_i,
  input logic [3:0]  amp_i,
  input logic [11:0] base_i,
  input logic [11:0] data_o,
  input logic        valid_o
);
  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (data_o == 12'd0 && !valid_o));

  p_pass_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_en_i |=> (valid_o && data_o == $past(base_i)));

  p_idle_no_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_en_i && !trig_i) |=> !valid_o);

  p_trig_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_en_i && trig_i) |=> valid_o);

  p_mode_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_en_i && trig_i && mode_i == 2'b00) |=> data_o == $past(base_i));

  p_noise_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_en_i && trig_i && mode_i == 2'b01) |=>
      (((data_o - $past(base_i)) & ~{6'd0, wave_gen_pkg::amp_span($past(amp_i))}) == 12'd0));

  p_tri_peak_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_en_i && trig_i && mode_i[1]) |=>
      ((data_o - $past(base_i)) <= {6'd0, wave_gen_pkg::amp_span($past(amp_i))}));
endmodule

bind wave_gen wave_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .trig_en_i(trig_en_i),
  .trig_i   (trig_i),
  .mode_i   (mode_i),
  .amp_i    (amp_i),
  .base_i   (base_i),
  .data_o   (data_o),
  .valid_o  (valid_o)
);

// File: tb/tb_wave_gen.sv
module tb_wave_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_en_i = 1'b0, trig_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [3:0]  amp_i = 4'd0;
  logic [11:0] base_i = 12'd0;
  logic [11:0] data_o;
  logic        valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic        vld;
    logic [11:0] dat;
    string       tag;
  } exp_t;
  exp_t q[$];

  // reference model state
  logic [11:0] m_lfsr = 12'hACE;
  logic [5:0]  m_cnt = 6'd0;
  logic        m_down = 1'b0;
  logic [1:0]  m_mode = 2'b00;

  always #5 clk_i = ~clk_i;

  wave_gen dut (.*);

  function automatic logic [5:0] span_of(input logic [3:0] a);
    int p;
    p = (a >= 5) ? 63 : (2 ** (a + 1)) - 1;
    return 6'(p);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic tr, input logic [1:0] md,
                      input logic [3:0] am, input logic [11:0] b, input string tag);
    exp_t e;
    logic [5:0] cnt_e, w;
    logic       down_e;
    @(negedge clk_i);
    #1;
    trig_en_i = en; trig_i = tr; mode_i = md; amp_i = am; base_i = b;
    cnt_e  = (md != m_mode) ? 6'd0 : m_cnt;
    down_e = (md != m_mode) ? 1'b0 : m_down;
    w = 6'd0;
    if (en && md == 2'b01) w = m_lfsr[5:0] & span_of(am);
    else if (en && md[1])  w = cnt_e;
    e.vld = !en || tr;
    e.dat = b + {6'd0, w};
    e.tag = tag;
    q.push_back(e);
    if (en && tr && md == 2'b01)
      m_lfsr = {m_lfsr[10:0], m_lfsr[11] ^ m_lfsr[5] ^ m_lfsr[3] ^ m_lfsr[0]};
    if (en && tr && md[1]) begin
      if (!down_e) begin
        if (cnt_e >= span_of(am)) begin down_e = 1'b1; cnt_e = cnt_e - 1; end
        else cnt_e = cnt_e + 1;
      end else begin
        if (cnt_e == 0) begin down_e = 1'b0; cnt_e = 6'd1; end
        else cnt_e = cnt_e - 1;
      end
    end
    m_cnt = cnt_e; m_down = down_e; m_mode = md;
  endtask

  // monitor: compares the result of the previous cycle's stimulus
  logic [11:0] last_dat = 12'd0;
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(valid_o == e.vld, {e.tag, " valid"}, {11'd0, valid_o}, {11'd0, e.vld});
        if (e.vld) begin
          check(data_o == e.dat, {e.tag, " data"}, data_o, e.dat);
          last_dat = e.dat;
        end else begin
          check(data_o == last_dat, {e.tag, " hold"}, data_o, last_dat);
        end
      end
    end
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #23;
    check(data_o == 12'd0 && valid_o == 1'b0, "R1 reset", data_o, 12'd0);
    @(negedge clk_i); #1 rst_ni = 1'b1;

    // R2 disabled: pass-through every clock, trigger/mode/amp ignored
    step(0, 0, 2'b01, 4'd7, 12'h123, "R2 off");
    step(0, 1, 2'b10, 4'd3, 12'hFFF, "R2 off trig");
    step(0, 0, 2'b11, 4'd0, 12'h456, "R2 off mode");

    // R3/R4 pass mode
    step(1, 1, 2'b00, 4'd5, 12'h700, "R4 pass");
    step(1, 0, 2'b00, 4'd5, 12'h701, "R3 idle");
    step(1, 1, 2'b00, 4'd9, 12'hABC, "R4 pass2");

    // R5/R6 noise, every amplitude code
    for (int a = 0; a < 16; a++) begin
      step(1, 1, 2'b01, 4'(a), 12'h100, "R5 R6 noise");
      step(1, 0, 2'b01, 4'(a), 12'h100, "R11 noise idle");
    end
    // R10 wrap in noise mode
    for (int i = 0; i < 6; i++) step(1, 1, 2'b01, 4'd7, 12'hFFE, "R10 noise wrap");
    step(0, 1, 2'b01, 4'd7, 12'h010, "R11 disabled noise");
    step(1, 1, 2'b01, 4'd4, 12'h010, "R5 resume");

    // R7/R8 triangle, small peaks
    for (int i = 0; i < 10; i++) step(1, 1, 2'b10, 4'd0, 12'h200, "R8 peak1");
    for (int i = 0; i < 18; i++) step(1, 1, 2'b10, 4'd2, 12'h200, "R7 peak7");
    step(1, 0, 2'b10, 4'd2, 12'h200, "R11 tri idle");
    for (int i = 0; i < 4; i++) step(1, 1, 2'b10, 4'd2, 12'h200, "R11 tri resume");
    // R9 mode change mid-ramp, 10 -> 11
    step(1, 1, 2'b11, 4'd2, 12'h200, "R9 change");
    for (int i = 0; i < 5; i++) step(1, 1, 2'b11, 4'd2, 12'h200, "R9 after");
    // R9 change without trigger, then back
    step(1, 0, 2'b00, 4'd2, 12'h200, "R9 to pass");
    for (int i = 0; i < 4; i++) step(1, 1, 2'b10, 4'd2, 12'h200, "R9 restart");
    // R8 saturated peak with R10 wrap
    for (int i = 0; i < 140; i++) step(1, 1, 2'b11, 4'd15, 12'hFF0, "R8 R10 peak63");
    for (int i = 0; i < 20; i++) step(1, 1, 2'b11, 4'd4, 12'h000, "R8 peak31");
    step(0, 0, 2'b11, 4'd4, 12'h321, "R2 end");
    step(1, 0, 2'b11, 4'd4, 12'h321, "R3 end idle");

    @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule